// File: doc/BRIEF.md
# Descriptor-Chained Memory-to-Stream DMA Engine

This block is the outbound half of a DMA channel. Given the address of a first data descriptor and of a context descriptor, it walks a linked list of data descriptors held in memory. For each descriptor it reads the bytes of the buffer it points to and delivers them one byte at a time on a valid/ready stream, marking the final byte of a packet with `last`. It writes each finished descriptor back to memory and follows its next pointer. When it finishes a descriptor flagged as end of list, it sets a disable bit in the context descriptor and stops.

Every data descriptor occupies four consecutive 32-bit words: the next pointer at offset 0, the buffer start at offset 4, a flag word at offset 8 and the buffer end (exclusive) at offset 12. In the flag word, bit 0 marks end of list, bit 3 asks for end-of-packet on output, bit 4 asks for an interrupt on completion, and bits [31:16] carry a 16-bit metadata tag. The remaining flag bits are carried through unchanged. At the start of every packet the engine presents the current descriptor's tag on a separate metadata port. A one-cycle interrupt-set pulse goes to the channel control unit.

All three data interfaces use valid/ready handshakes. The engine holds a request, byte or tag stable until the other side accepts it, so back-pressure only stretches time. The memory port carries one request at a time: a read returns exactly one `mem_rsp_valid_i` pulse, which the engine always accepts. Writes get no response.

Top module: `desc_stream_dma`

## Requirements
- R1: On `run_i`, the engine first reads the current descriptor's four words at D, D+4, D+8 and D+12, in that order.
- R2: The bytes from buffer start up to buffer end minus one appear on the stream in ascending address order. The byte at address A is bits [8*(A mod 4)+7 : 8*(A mod 4)] of the 32-bit word at A with its two low bits cleared.
- R3: `st_last_o` is high only on the byte at buffer end minus one, and only when flag bit 3 of that descriptor is set.
- R4: The flag word's bits [31:16] are offered on the metadata port before any byte of a packet. A packet starts at the first descriptor of a run and at each descriptor that follows one with flag bit 3 set. No tag is offered for other descriptors, and no byte is offered while a tag is pending.
- R5: Completion of a descriptor with flag bit 4 set gives a single-cycle pulse on `irq_set_o` bit 2. No other bit of `irq_set_o` ever rises.
- R6: After its bytes, each descriptor's four words are written back unchanged to D, D+4, D+8 and D+12.
- R7: If flag bit 0 is clear, the engine fetches the descriptor at the next pointer and restarts the byte position at that descriptor's buffer start.
- R8: If flag bit 0 is set, the engine reads the context flag word at C+4 and writes it back with bit 15 set. It then raises `eol_o` and returns to idle.
- R9: While `eol_o` is high, `run_i` is ignored and no memory request is issued. `load_i` in idle captures D and C and clears `eol_o`. `load_i` has priority over `run_i`.
- R10: A descriptor whose end is not above its start emits no bytes but still completes, writes back and chains.
- R11: A valid on the stream, metadata or memory request port stays high with unchanged payload until its ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Capture descriptor and context addresses (idle only) |
| load_desc_i | input | ADDR_W | First data descriptor address |
| load_ctx_i | input | ADDR_W | Context descriptor address |
| run_i | input | 1 | Start walking the list |
| busy_o | output | 1 | Engine not idle |
| eol_o | output | 1 | End of list reached |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_write_o | output | 1 | 1 = write, 0 = read |
| mem_req_addr_o | output | ADDR_W | Word address of request |
| mem_req_wdata_o | output | WORD_W | Write data |
| mem_rsp_valid_i | input | 1 | Read data valid (one pulse per read) |
| mem_rsp_data_i | input | WORD_W | Read data |
| st_valid_o | output | 1 | Stream byte valid |
| st_ready_i | input | 1 | Stream byte accepted |
| st_data_o | output | 8 | Stream byte |
| st_last_o | output | 1 | End of packet |
| md_valid_o | output | 1 | Metadata valid |
| md_ready_i | input | 1 | Metadata accepted |
| md_data_o | output | MD_W | Metadata tag |
| irq_set_o | output | IRQ_W | Interrupt-set pulses, bit 2 = descriptor done |

## Verification
A wrong byte position or end pointer shows up on the stream within one word fetch: a byte is missing, repeated or out of order, or `last` falls on the wrong byte. A bad chaining or write-back state shows up in the write addresses on the memory port right after the descriptor's last byte. A stale packet-start flag shows up as an extra or missing tag before the next descriptor's data. A faulty end-of-list state either issues requests after `eol_o` or never writes the context word, and either is visible within a few cycles of the final write-back.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH_REQ,
    ST_FETCH_RSP,
    ST_META,
    ST_SCAN,
    ST_DATA_REQ,
    ST_DATA_RSP,
    ST_EMIT,
    ST_WB_REQ,
    ST_STEP,
    ST_CTX_REQ,
    ST_CTX_RSP,
    ST_CTX_WR
  } dsd_state_e;

  localparam int unsigned DESC_WORDS  = 4;
  localparam int unsigned FLAG_EOL    = 0;
  localparam int unsigned FLAG_OEOP   = 3;
  localparam int unsigned FLAG_INTR   = 4;
  localparam int unsigned FLAG_MD_LSB = 16;
  localparam int unsigned CTX_DIS_BIT = 15;

endpackage

// File: rtl/dsd_desc_store.sv
module dsd_desc_store
  import dsd_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 32,
  parameter int MD_W   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [1:0]            idx_i,
  input  logic [WORD_W-1:0]     data_i,
  output logic [WORD_W-1:0]     rd_o,
  output logic [ADDR_W-1:0]     next_o,
  output logic [ADDR_W-1:0]     buf_o,
  output logic [ADDR_W-1:0]     end_o,
  output logic                  eol_o,
  output logic                  oeop_o,
  output logic                  intr_o,
  output logic [MD_W-1:0]       md_o
);

  logic [WORD_W-1:0] words_q [DESC_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DESC_WORDS; w++) words_q[w] <= '0;
    end else if (wr_i) begin
      words_q[idx_i] <= data_i;
    end
  end

  assign rd_o   = words_q[idx_i];
  assign next_o = words_q[0][ADDR_W-1:0];
  assign buf_o  = words_q[1][ADDR_W-1:0];
  assign end_o  = words_q[3][ADDR_W-1:0];
  assign eol_o  = words_q[2][FLAG_EOL];
  assign oeop_o = words_q[2][FLAG_OEOP];
  assign intr_o = words_q[2][FLAG_INTR];
  assign md_o   = words_q[2][FLAG_MD_LSB +: MD_W];

endmodule

// File: rtl/dsd_byte_emit.sv
module dsd_byte_emit #(
  parameter int WORD_W = 32,
  parameter int LANE_W = $clog2(WORD_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [LANE_W-1:0] first_i,
  input  logic [LANE_W-1:0] stop_i,
  input  logic              tail_i,
  output logic              st_valid_o,
  input  logic              st_ready_i,
  output logic [7:0]        st_data_o,
  output logic              st_last_o,
  output logic              done_o
);

  logic              active_q;
  logic [WORD_W-1:0] word_q;
  logic [LANE_W-1:0] lane_q;
  logic [LANE_W-1:0] stop_q;
  logic              tail_q;
  logic              at_stop;

  assign at_stop = (lane_q == stop_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      word_q   <= '0;
      lane_q   <= '0;
      stop_q   <= '0;
      tail_q   <= 1'b0;
    end else if (load_i) begin
      active_q <= 1'b1;
      word_q   <= word_i;
      lane_q   <= first_i;
      stop_q   <= stop_i;
      tail_q   <= tail_i;
    end else if (active_q && st_ready_i) begin
      if (at_stop) active_q <= 1'b0;
      else         lane_q   <= lane_q + 1'b1;
    end
  end

  assign st_valid_o = active_q;
  assign st_data_o  = word_q[{lane_q, 3'b000} +: 8];
  assign st_last_o  = active_q && tail_q && at_stop;
  assign done_o     = active_q && st_ready_i && at_stop;

  // R11
  st_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid_o && !st_ready_i |=> st_valid_o && $stable(st_data_o) && $stable(st_last_o))
    else $error("stream byte changed before acceptance");

endmodule

// File: rtl/desc_stream_dma.sv
module desc_stream_dma
  import dsd_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int MD_W        = 16,
  parameter int IRQ_W       = 4,
  parameter int IRQ_DONE_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_desc_i,
  input  logic [ADDR_W-1:0] load_ctx_i,
  input  logic              run_i,
  output logic              busy_o,
  output logic              eol_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_write_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [WORD_W-1:0] mem_req_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic [WORD_W-1:0] mem_rsp_data_i,
  output logic              st_valid_o,
  input  logic              st_ready_i,
  output logic [7:0]        st_data_o,
  output logic              st_last_o,
  output logic              md_valid_o,
  input  logic              md_ready_i,
  output logic [MD_W-1:0]   md_data_o,
  output logic [IRQ_W-1:0]  irq_set_o
);

  localparam int LANES  = WORD_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int CNT_W  = LANE_W + 1;
  localparam logic [1:0] LAST_IDX = 2'(DESC_WORDS - 1);

  dsd_state_e        state_q;
  logic [ADDR_W-1:0] cur_q, ctx_q, pos_q;
  logic [1:0]        idx_q;
  logic              eol_q, pkt_q, irq_q;
  logic [WORD_W-1:0] ctxw_q;

  logic [WORD_W-1:0] dsc_rd;
  logic [ADDR_W-1:0] dsc_next, dsc_buf, dsc_end;
  logic              dsc_eol, dsc_oeop, dsc_intr;
  logic [MD_W-1:0]   dsc_md;
  logic              dsc_wr;

  logic [ADDR_W-1:0] remain;
  logic              have_bytes, fits;
  logic [CNT_W-1:0]  room, take, hi_sum;
  logic [LANE_W-1:0] lo_lane;
  logic              emit_load, emit_done;

  assign dsc_wr = (state_q == ST_FETCH_RSP) && mem_rsp_valid_i;

  dsd_desc_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .MD_W(MD_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (dsc_wr),
    .idx_i  (idx_q),
    .data_i (mem_rsp_data_i),
    .rd_o   (dsc_rd),
    .next_o (dsc_next),
    .buf_o  (dsc_buf),
    .end_o  (dsc_end),
    .eol_o  (dsc_eol),
    .oeop_o (dsc_oeop),
    .intr_o (dsc_intr),
    .md_o   (dsc_md)
  );

  // Chunk sizing for the current word
  always_comb begin
    lo_lane    = pos_q[LANE_W-1:0];
    remain     = dsc_end - pos_q;
    have_bytes = dsc_end > pos_q;
    room       = CNT_W'(LANES) - {1'b0, lo_lane};
    fits       = remain <= ADDR_W'(room);
    take       = fits ? remain[CNT_W-1:0] : room;
    hi_sum     = {1'b0, lo_lane} + take - CNT_W'(1);
  end

  assign emit_load = (state_q == ST_DATA_RSP) && mem_rsp_valid_i;

  dsd_byte_emit #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_emit (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (emit_load),
    .word_i     (mem_rsp_data_i),
    .first_i    (lo_lane),
    .stop_i     (hi_sum[LANE_W-1:0]),
    .tail_i     (fits && dsc_oeop),
    .st_valid_o (st_valid_o),
    .st_ready_i (st_ready_i),
    .st_data_o  (st_data_o),
    .st_last_o  (st_last_o),
    .done_o     (emit_done)
  );

  // Sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      ctx_q   <= '0;
      pos_q   <= '0;
      idx_q   <= '0;
      eol_q   <= 1'b0;
      pkt_q   <= 1'b0;
      irq_q   <= 1'b0;
      ctxw_q  <= '0;
    end else begin
      irq_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (load_i) begin
            cur_q <= load_desc_i;
            ctx_q <= load_ctx_i;
            eol_q <= 1'b0;
          end else if (run_i && !eol_q) begin
            pkt_q   <= 1'b1;
            idx_q   <= '0;
            state_q <= ST_FETCH_REQ;
          end
        end
        ST_FETCH_REQ: if (mem_req_ready_i) state_q <= ST_FETCH_RSP;
        ST_FETCH_RSP: begin
          if (mem_rsp_valid_i) begin
            if (idx_q == LAST_IDX) begin
              idx_q   <= '0;
              pos_q   <= dsc_buf;
              state_q <= pkt_q ? ST_META : ST_SCAN;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_FETCH_REQ;
            end
          end
        end
        ST_META: begin
          if (md_ready_i) begin
            pkt_q   <= 1'b0;
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (have_bytes) begin
            state_q <= ST_DATA_REQ;
          end else begin
            irq_q   <= dsc_intr;
            pkt_q   <= dsc_oeop;
            idx_q   <= '0;
            state_q <= ST_WB_REQ;
          end
        end
        ST_DATA_REQ: if (mem_req_ready_i) state_q <= ST_DATA_RSP;
        ST_DATA_RSP: begin
          if (mem_rsp_valid_i) begin
            pos_q   <= pos_q + ADDR_W'(take);
            state_q <= ST_EMIT;
          end
        end
        ST_EMIT: if (emit_done) state_q <= ST_SCAN;
        ST_WB_REQ: begin
          if (mem_req_ready_i) begin
            if (idx_q == LAST_IDX) begin
              idx_q   <= '0;
              state_q <= ST_STEP;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_STEP: begin
          if (dsc_eol) begin
            state_q <= ST_CTX_REQ;
          end else begin
            cur_q   <= dsc_next;
            state_q <= ST_FETCH_REQ;
          end
        end
        ST_CTX_REQ: if (mem_req_ready_i) state_q <= ST_CTX_RSP;
        ST_CTX_RSP: begin
          if (mem_rsp_valid_i) begin
            ctxw_q  <= mem_rsp_data_i;
            state_q <= ST_CTX_WR;
          end
        end
        ST_CTX_WR: begin
          if (mem_req_ready_i) begin
            eol_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Memory request mux
  always_comb begin
    mem_req_valid_o = 1'b0;
    mem_req_write_o = 1'b0;
    mem_req_addr_o  = '0;
    mem_req_wdata_o = '0;
    case (state_q)
      ST_FETCH_REQ: begin
        mem_req_valid_o = 1'b1;
        mem_req_addr_o  = cur_q + (ADDR_W'(idx_q) << LANE_W);
      end
      ST_DATA_REQ: begin
        mem_req_valid_o = 1'b1;
        mem_req_addr_o  = {pos_q[ADDR_W-1:LANE_W], LANE_W'(0)};
      end
      ST_WB_REQ: begin
        mem_req_valid_o = 1'b1;
        mem_req_write_o = 1'b1;
        mem_req_addr_o  = cur_q + (ADDR_W'(idx_q) << LANE_W);
        mem_req_wdata_o = dsc_rd;
      end
      ST_CTX_REQ: begin
        mem_req_valid_o = 1'b1;
        mem_req_addr_o  = ctx_q + ADDR_W'(LANES);
      end
      ST_CTX_WR: begin
        mem_req_valid_o = 1'b1;
        mem_req_write_o = 1'b1;
        mem_req_addr_o  = ctx_q + ADDR_W'(LANES);
        mem_req_wdata_o = ctxw_q | (WORD_W'(1) << CTX_DIS_BIT);
      end
      default: ;
    endcase
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign eol_o      = eol_q;
  assign md_valid_o = (state_q == ST_META);
  assign md_data_o  = dsc_md;
  assign irq_set_o  = IRQ_W'(irq_q) << IRQ_DONE_BIT;

  // R11
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o)
      && $stable(mem_req_write_o) && $stable(mem_req_wdata_o))
    else $error("memory request changed before acceptance");

  // R11
  md_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    md_valid_o && !md_ready_i |=> md_valid_o && $stable(md_data_o))
    else $error("metadata changed before acceptance");

  // R4
  md_before_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    md_valid_o |-> !st_valid_o)
    else $error("byte offered while a tag is pending");

  // R3
  last_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid_o && st_last_o |-> dsc_oeop)
    else $error("last on a descriptor without end-of-packet");

  // R5
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set_o[IRQ_DONE_BIT] |=> !irq_set_o[IRQ_DONE_BIT])
    else $error("interrupt pulse longer than one cycle");

  // R9
  eol_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eol_o && !load_i |=> !mem_req_valid_o)
    else $error("memory request after end of list");

endmodule

// File: tb/desc_stream_dma_test.sv
`timescale 1ns/1ps
module desc_stream_dma_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0, run_i = 1'b0;
  logic [31:0] load_desc_i = '0, load_ctx_i = '0;
  logic        busy_o, eol_o;
  logic        mem_req_valid_o, mem_req_write_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_req_addr_o, mem_req_wdata_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic        st_valid_o, st_last_o;
  logic        st_ready_i = 1'b0;
  logic [7:0]  st_data_o;
  logic        md_valid_o;
  logic        md_ready_i = 1'b0;
  logic [15:0] md_data_o;
  logic [3:0]  irq_set_o;

  always #2 clk = ~clk;

  desc_stream_dma uut (.*);

  logic [31:0] mem [0:4095];
  int checks = 0, errors = 0, stall_lvl = 0, hold_err = 0, bad_irq = 0, irq_cnt = 0;
  bit finished = 1'b0;
  logic [8:0]  got_b[$], exp_b[$];
  logic [15:0] got_md[$], exp_md[$];
  logic [63:0] got_wr[$], exp_wr[$];
  logic [31:0] got_rd[$];
  int exp_irq;

  function automatic logic [7:0] byte_at(input logic [31:0] a);
    return mem[a[13:2]][{a[1:0], 3'b000} +: 8];
  endfunction

  function automatic bit rdy();
    return ($urandom % 4) >= stall_lvl;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint got, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Reference walk of the list, from the requirements
  task automatic build_exp(input logic [31:0] d0, input logic [31:0] c0);
    logic [31:0] d, nx, bf, fl, en;
    bit send;
    exp_b.delete(); exp_md.delete(); exp_wr.delete(); exp_irq = 0;
    d = d0; send = 1'b1;
    for (int n = 0; n < 64; n++) begin
      nx = mem[d[13:2]]; bf = mem[d[13:2] + 1]; fl = mem[d[13:2] + 2]; en = mem[d[13:2] + 3];
      if (send) exp_md.push_back(fl[31:16]);
      send = 1'b0;
      for (logic [31:0] a = bf; a < en; a++) exp_b.push_back({(a == en - 1) && fl[3], byte_at(a)});
      if (fl[4]) exp_irq++;
      exp_wr.push_back({d, nx}); exp_wr.push_back({d + 4, bf});
      exp_wr.push_back({d + 8, fl}); exp_wr.push_back({d + 12, en});
      if (fl[3]) send = 1'b1;
      if (fl[0]) begin
        exp_wr.push_back({c0 + 4, mem[c0[13:2] + 1] | 32'h8000});
        break;
      end
      d = nx;
    end
  endtask

  // Memory model, readies and port monitor
  logic s_req, s_wr, pst_w, pmd_w, prq_w, pst_l, prq_wr, rsp_pend;
  logic [31:0] s_addr, s_data, prq_a, prq_d, rsp_word;
  logic [7:0]  pst_d;
  logic [15:0] pmd_d;
  int rsp_delay;
  initial begin pst_w = 0; pmd_w = 0; prq_w = 0; rsp_pend = 0; rsp_delay = 0; end

  always begin
    @(negedge clk);
    s_req = mem_req_valid_o && mem_req_ready_i;
    s_wr = mem_req_write_o; s_addr = mem_req_addr_o; s_data = mem_req_wdata_o;
    if (st_valid_o && st_ready_i) got_b.push_back({st_last_o, st_data_o});
    if (md_valid_o && md_ready_i) got_md.push_back(md_data_o);
    if (irq_set_o[2]) irq_cnt++;
    if ((irq_set_o & 4'b1011) != 0) bad_irq++;
    if (pst_w && !(st_valid_o && st_data_o == pst_d && st_last_o == pst_l)) hold_err++;
    if (pmd_w && !(md_valid_o && md_data_o == pmd_d)) hold_err++;
    if (prq_w && !(mem_req_valid_o && mem_req_addr_o == prq_a && mem_req_wdata_o == prq_d
                   && mem_req_write_o == prq_wr)) hold_err++;
    pst_w = st_valid_o && !st_ready_i; pst_d = st_data_o; pst_l = st_last_o;
    pmd_w = md_valid_o && !md_ready_i; pmd_d = md_data_o;
    prq_w = mem_req_valid_o && !mem_req_ready_i; prq_a = mem_req_addr_o;
    prq_d = mem_req_wdata_o; prq_wr = mem_req_write_o;
    @(posedge clk); #1;
    mem_rsp_valid_i = 1'b0;
    if (s_req && rst_n) begin
      if (s_wr) begin
        mem[s_addr[13:2]] = s_data;
        got_wr.push_back({s_addr, s_data});
      end else begin
        got_rd.push_back(s_addr);
        rsp_word = mem[s_addr[13:2]];
        rsp_delay = $urandom % 3;
        rsp_pend = 1'b1;
      end
    end
    if (rsp_pend) begin
      if (rsp_delay == 0) begin
        mem_rsp_valid_i = 1'b1; mem_rsp_data_i = rsp_word; rsp_pend = 1'b0;
      end else rsp_delay--;
    end
    mem_req_ready_i = rdy(); st_ready_i = rdy(); md_ready_i = rdy();
  end

  task automatic do_run(input logic [31:0] d0, input logic [31:0] c0, input string name);
    build_exp(d0, c0);
    got_b.delete(); got_md.delete(); got_wr.delete(); got_rd.delete(); irq_cnt = 0;
    @(posedge clk); #1; load_i = 1'b1; load_desc_i = d0; load_ctx_i = c0;
    @(posedge clk); #1; load_i = 1'b0; run_i = 1'b1;
    @(negedge clk);
    chk(eol_o == 1'b0, "R9", {name, " load clears eol"}, eol_o, 0);
    @(posedge clk); #1; run_i = 1'b0;
    for (int k = 0; k < 40000 && !(eol_o && !busy_o); k++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(eol_o && !busy_o, "R8", {name, " stops with eol"}, eol_o, 1);
    chk(got_rd.size() >= 4, "R1", {name, " fetch count"}, got_rd.size(), 4);
    for (int i = 0; i < 4 && i < got_rd.size(); i++)
      chk(got_rd[i] == d0 + 4 * i, "R1", {name, " fetch address"}, got_rd[i], d0 + 4 * i);
    chk(got_b.size() == exp_b.size(), "R2", {name, " byte count"}, got_b.size(), exp_b.size());
    for (int i = 0; i < got_b.size() && i < exp_b.size(); i++) begin
      chk(got_b[i][7:0] == exp_b[i][7:0], "R2", {name, " byte"}, got_b[i][7:0], exp_b[i][7:0]);
      chk(got_b[i][8] == exp_b[i][8], "R3", {name, " last"}, got_b[i][8], exp_b[i][8]);
    end
    chk(got_md.size() == exp_md.size(), "R4", {name, " tag count"}, got_md.size(), exp_md.size());
    for (int i = 0; i < got_md.size() && i < exp_md.size(); i++)
      chk(got_md[i] == exp_md[i], "R4", {name, " tag"}, got_md[i], exp_md[i]);
    chk(irq_cnt == exp_irq, "R5", {name, " irq pulses"}, irq_cnt, exp_irq);
    chk(got_wr.size() == exp_wr.size(), "R6", {name, " write count"}, got_wr.size(), exp_wr.size());
    for (int i = 0; i < got_wr.size() && i < exp_wr.size(); i++)
      chk(got_wr[i] == exp_wr[i], (i == exp_wr.size() - 1) ? "R8" : "R6",
          {name, " write addr/data"}, got_wr[i], exp_wr[i]);
  endtask

  task automatic put_desc(input logic [31:0] d, input logic [31:0] nx, input logic [31:0] bf,
                          input logic [31:0] fl, input logic [31:0] en);
    mem[d[13:2]] = nx; mem[d[13:2] + 1] = bf; mem[d[13:2] + 2] = fl; mem[d[13:2] + 3] = en;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, got 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d, bf, fl;
    int n, len;
    void'($urandom(32'h5eed_0d5a));
    for (int i = 0; i < 4096; i++) mem[i] = $urandom;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!st_valid_o && !md_valid_o && !mem_req_valid_o, "R11", "reset valids", 0, 0);
    chk(!eol_o && !busy_o && irq_set_o == 0, "R8", "reset state", {eol_o, busy_o}, 0);

    // Directed: one unaligned descriptor spanning three words
    put_desc(32'h40, 32'h0, 32'h1003, 32'hBEEF_0019, 32'h100B);
    mem[32'h804 >> 2] = 32'h0000_0021;
    do_run(32'h40, 32'h800, "single");
    chk(mem[32'h804 >> 2] == 32'h8021, "R8", "context disable bit", mem[32'h804 >> 2], 32'h8021);

    // Run while at end of list is ignored
    got_rd.delete(); got_b.delete();
    @(posedge clk); #1 run_i = 1'b1;
    @(posedge clk); #1 run_i = 1'b0;
    repeat (30) @(negedge clk);
    chk(got_rd.size() == 0 && !busy_o, "R9", "run after eol ignored", got_rd.size(), 0);
    chk(eol_o == 1'b1, "R9", "eol held", eol_o, 1);

    // Chain with a zero-length middle descriptor
    stall_lvl = 2;
    put_desc(32'h100, 32'h140, 32'h1100, 32'hA001_0008, 32'h1106);
    put_desc(32'h140, 32'h180, 32'h1200, 32'hB002_0010, 32'h1200);
    put_desc(32'h180, 32'h0,   32'h1301, 32'hC003_0011, 32'h1303);
    mem[32'h904 >> 2] = 32'h0;
    do_run(32'h100, 32'h900, "chain");
    chk(got_b.size() == 8, "R10", "zero-length adds no bytes", got_b.size(), 8);
    chk(got_rd.size() > 12 && got_rd.size() > 0, "R7", "third descriptor fetched", got_rd.size(), 13);
    chk(got_md.size() == 2, "R4", "tags after eop only", got_md.size(), 2);

    // Random chains under varying back-pressure
    for (int it = 0; it < 24; it++) begin
      stall_lvl = it % 4;
      n = 1 + ($urandom % 4);
      for (int j = 0; j < n; j++) begin
        d = 32'h200 + 32'h40 * j;
        bf = 32'h2000 + 32'h100 * j + ($urandom % 8);
        len = (($urandom % 5) == 0) ? 0 : 1 + ($urandom % 24);
        fl = {16'($urandom), 16'h0} | (($urandom % 2) ? 32'h8 : 32'h0)
             | (($urandom % 2) ? 32'h10 : 32'h0) | ((j == n - 1) ? 32'h1 : 32'h0);
        put_desc(d, d + 32'h40, bf, fl, bf + len);
      end
      mem[32'hA04 >> 2] = $urandom;
      do_run(32'h200, 32'hA00, "random");
    end

    chk(hold_err == 0, "R11", "payload held under back-pressure", hold_err, 0);
    chk(bad_irq == 0, "R5", "only bit 2 pulses", bad_irq, 0);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule